// File: doc/BRIEF.md
# Polled Eight-Level Interrupt Controller

This block gathers eight interrupt request lines, remembers which of them have fired, and tells a bus master through one interrupt output that something needs service. The master never runs an acknowledge cycle. It writes a command word that arms a poll. Its next read returns a flag and the 3-bit number of the winning level, and that read is the acknowledge: the level moves from the pending set to the in-service set. When the service routine ends, the master writes an end-of-interrupt word to release the level.

Access goes through a byte-wide register port with active-low chip select, write and read strobes, and one address bit. The strobes and the data are synchronised to the system clock, and each strobe acts once, on its falling edge. Priority is resolved in rotating order from a programmable lowest level. Nesting follows the in-service set. A special mask mode lets lower levels through while a higher level is being serviced. The two initialisation words are accepted so that existing driver code runs unchanged, but their contents are not used.

Top module: `poll_irq_ctrl`

## Requirements
- R1: A low-to-high transition on `irq_req[k]` sets request bit k. A line that stays high does not set the bit again.
- R2: While mask bit k is 1, request bit k reads as 0. A rising edge that arrives while the level is masked is lost and is not restored when the mask bit is cleared.
- R3: A write at address 1 loads the mask register from `din`. A read at address 1 returns the mask register, and no command has to come first.
- R4: A write at address 0 with `din[4:3]=01` and `din[2]=1` arms a poll. If an eligible request exists, the next read returns `8'h80 | level`, sets that level's in-service bit and clears its request bit.
- R5: A poll read that finds no eligible request returns `8'h00` and changes no request or in-service bit.
- R6: In the same word as R4, `din[1:0]=10` selects the request register and `11` selects the in-service register for reads at address 0. The selection holds until it is changed. An armed poll serves exactly one read, and it takes precedence over a selection written in the same word.
- R7: A write at address 0 with `din[4:3]=00` and `din[7:5]=001` clears the highest-priority set in-service bit. With `din[7:5]=101` it does the same and also makes that level the lowest priority.
- R8: With `din[4:3]=00` and `din[7:5]=011`, the in-service bit named by `din[2:0]` is cleared.
- R9: With `din[4:3]=00` and `din[7:5]=110`, the level in `din[2:0]` becomes the lowest priority and the next level up (mod 8) becomes the highest. `111` does the same and also clears that level's in-service bit. After reset, level 0 is highest and level 7 is lowest.
- R10: With `din[4:3]=01`, `din[6:5]=11` turns special mask mode on and `10` turns it off. In this mode, any pending level whose own in-service bit is clear is eligible, whatever else is in service.
- R11: Outside special mask mode, a request is eligible only if it outranks every set in-service bit. `irq_out` is high exactly when an eligible request exists.
- R12: A write at address 0 with `din[4]=1` starts initialisation, whatever `din[3:0]` holds. It clears the mask, the request bits, the special mask mode, the armed poll and the read selection (back to the request register), and it restores the default priority. A line already high needs a fresh rising edge. The next write, at either address, is discarded. Reset leaves the same state.
- R13: Each access acts once, on the synchronised falling edge of its strobe while `cs_n` is low. A strobe held low for longer does not repeat the access, and a strobe with `cs_n` high does nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| wr_n | input | 1 | Write strobe, active low |
| rd_n | input | 1 | Read strobe, active low |
| addr | input | 1 | Register address bit |
| din | input | 8 | Write data |
| dout | output | 8 | Registered read data, held between reads |
| irq_req | input | 8 | Interrupt request lines, rising-edge sensitive |
| irq_out | output | 1 | Interrupt toward the bus master |

## Verification
The bench targets the interplay of nesting and rotation. It checks a lower request held off behind a higher level in service, and special mask mode letting that request through. A design that compared raw level numbers instead of rotated ranks would pick the wrong winner once the lowest level is moved, and the bench catches this. Lost edges are probed by toggling a line while it is masked and then unmasking it, and by holding lines high across initialisation; a level-sensitive capture would show a spurious pending bit. One poll read is held low for many cycles while two levels are pending, which exposes an access that repeats on every low cycle. A poll with nothing eligible is checked for both its zero result and the untouched registers.

// File: rtl/pic_pkg.sv
package pic_pkg;
  localparam int NUM_LVL = 8;
  localparam int LVL_W   = $clog2(NUM_LVL);
  localparam int DATA_W  = 8;

  // command byte bit positions (decoded behaviour, fixed)
  localparam int B_INIT = 4;
  localparam int B_KIND = 3;
  localparam int B_POLL = 2;

  typedef struct packed {
    logic             skip;      // second init word, discarded
    logic             init;      // initialisation start
    logic             mask_ld;   // load mask register
    logic             eoi_top;   // clear highest in-service bit
    logic             rot_top;   // ... and make it lowest priority
    logic             eoi_lvl;   // clear named in-service bit
    logic             set_low;   // named level becomes lowest
    logic             smm_we;
    logic             smm_val;
    logic             sel_we;
    logic             sel_val;   // 1 = in-service register
    logic             mode_wr;   // mode word written (poll field valid)
    logic             poll;
    logic [LVL_W-1:0] lvl;
  } pic_cmd_t;
endpackage

// File: rtl/pic_sync.sv
module pic_sync #(
  parameter int unsigned W       = 1,
  parameter int unsigned STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < int'(STAGES); k++) chain[k] <= RST_VAL;
    end else begin
      chain[0] <= d;
      for (int k = 1; k < int'(STAGES); k++) chain[k] <= chain[k-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/pic_resolver.sv
// Finds the highest-priority set bit; priority starts one above 'low'
// and wraps, so 'low' itself is the lowest priority.
module pic_resolver #(
  parameter int unsigned N  = 8,
  parameter int unsigned LW = $clog2(N)
) (
  input  logic [N-1:0]  vec,
  input  logic [LW-1:0] low,
  output logic          found,
  output logic [LW-1:0] lvl
);
  logic [LW-1:0] idx;

  always_comb begin
    found = 1'b0;
    lvl   = '0;
    idx   = '0;
    for (int i = int'(N) - 1; i >= 0; i--) begin
      idx = low + LW'(i + 1);
      if (vec[idx]) begin
        found = 1'b1;
        lvl   = idx;
      end
    end
  end
endmodule

// File: rtl/pic_cmd_decode.sv
module pic_cmd_decode
  import pic_pkg::*;
(
  input  logic              addr,
  input  logic [DATA_W-1:0] data,
  input  logic              wait_second,
  output pic_cmd_t          cmd
);
  logic [2:0] op;
  logic       is_a0;

  assign op    = data[7:5];
  assign is_a0 = !addr && !wait_second;

  always_comb begin
    cmd         = '0;
    cmd.lvl     = data[LVL_W-1:0];
    cmd.skip    = wait_second;
    cmd.mask_ld = addr && !wait_second;
    if (is_a0) begin
      if (data[B_INIT]) begin
        cmd.init = 1'b1;
      end else if (!data[B_KIND]) begin
        unique case (op)
          3'b001: cmd.eoi_top = 1'b1;
          3'b101: begin cmd.eoi_top = 1'b1; cmd.rot_top = 1'b1; end
          3'b011: cmd.eoi_lvl = 1'b1;
          3'b110: cmd.set_low = 1'b1;
          3'b111: begin cmd.eoi_lvl = 1'b1; cmd.set_low = 1'b1; end
          default: ;
        endcase
      end else begin
        cmd.mode_wr = 1'b1;
        cmd.smm_we  = data[6];
        cmd.smm_val = data[5];
        cmd.sel_we  = data[1];
        cmd.sel_val = data[0];
        cmd.poll    = data[B_POLL];
      end
    end
  end
endmodule

// File: rtl/poll_irq_ctrl.sv
module poll_irq_ctrl
  import pic_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              wr_n,
  input  logic              rd_n,
  input  logic              addr,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  input  logic [NUM_LVL-1:0] irq_req,
  output logic              irq_out
);
  localparam int BUS_W = 4 + DATA_W;
  localparam logic [BUS_W-1:0] BUS_IDLE = {3'b111, {(1 + DATA_W){1'b0}}};
  localparam logic [LVL_W-1:0] LOW_DEF = LVL_W'(NUM_LVL - 1);
  localparam int PAD_W = DATA_W - 1 - LVL_W;

  // ---------------- synchronisers ----------------
  logic [BUS_W-1:0]   bus_s;
  logic [NUM_LVL-1:0] req_s;

  pic_sync #(.W(BUS_W), .STAGES(SYNC_STAGES), .RST_VAL(BUS_IDLE)) i_bus_sync (
    .clk(clk), .rst(rst), .d({cs_n, wr_n, rd_n, addr, din}), .q(bus_s)
  );
  pic_sync #(.W(NUM_LVL), .STAGES(SYNC_STAGES), .RST_VAL('0)) i_req_sync (
    .clk(clk), .rst(rst), .d(irq_req), .q(req_s)
  );

  logic              s_cs_n, s_wr_n, s_rd_n, s_addr;
  logic [DATA_W-1:0] s_data;
  assign {s_cs_n, s_wr_n, s_rd_n, s_addr, s_data} = bus_s;

  logic               wr_prev, rd_prev;
  logic [NUM_LVL-1:0] req_prev;
  logic               wr_evt, rd_evt, init_evt;
  logic [NUM_LVL-1:0] req_rise;

  assign wr_evt   = wr_prev && !s_wr_n && !s_cs_n;
  assign rd_evt   = rd_prev && !s_rd_n && !s_cs_n;
  assign req_rise = req_s & ~req_prev;

  // ---------------- state ----------------
  logic [NUM_LVL-1:0] irr_q, isr_q, imr_q;
  logic [LVL_W-1:0]   low_q;
  logic               smm_q, sel_isr_q, poll_q, second_q;

  pic_cmd_t cmd;
  pic_cmd_decode i_decode (
    .addr(s_addr), .data(s_data), .wait_second(second_q), .cmd(cmd)
  );
  assign init_evt = wr_evt && cmd.init;

  // ---------------- priority ----------------
  logic [NUM_LVL-1:0] cand_vec;
  logic               req_found, isv_found;
  logic [LVL_W-1:0]   req_lvl, isv_lvl;

  assign cand_vec = smm_q ? (irr_q & ~isr_q) : irr_q;

  pic_resolver #(.N(NUM_LVL), .LW(LVL_W)) i_req_res (
    .vec(cand_vec), .low(low_q), .found(req_found), .lvl(req_lvl)
  );
  pic_resolver #(.N(NUM_LVL), .LW(LVL_W)) i_isr_res (
    .vec(isr_q), .low(low_q), .found(isv_found), .lvl(isv_lvl)
  );

  function automatic logic [LVL_W-1:0] rank_of(input logic [LVL_W-1:0] l,
                                              input logic [LVL_W-1:0] lo);
    return l - lo - LVL_W'(1);
  endfunction

  logic grant;
  assign grant = req_found &&
                 (smm_q || !isv_found || (rank_of(req_lvl, low_q) < rank_of(isv_lvl, low_q)));

  logic poll_rd, poll_hit;
  assign poll_rd  = rd_evt && poll_q && !s_addr;
  assign poll_hit = poll_rd && grant;

  // ---------------- next state ----------------
  logic [NUM_LVL-1:0] irr_n, isr_n, imr_n, ack_bit, isr_clr;
  logic [LVL_W-1:0]   low_n;
  logic               smm_n, sel_n, poll_n, second_n;
  logic [DATA_W-1:0]  dout_n;

  always_comb begin
    ack_bit = '0;
    if (poll_hit) ack_bit[req_lvl] = 1'b1;

    isr_clr = '0;
    if (wr_evt && cmd.eoi_top && isv_found) isr_clr[isv_lvl] = 1'b1;
    if (wr_evt && cmd.eoi_lvl)              isr_clr[cmd.lvl] = 1'b1;

    imr_n = imr_q;
    if (wr_evt && cmd.mask_ld) imr_n = s_data[NUM_LVL-1:0];
    if (init_evt)              imr_n = '0;

    irr_n = init_evt ? '0 : (((irr_q & ~ack_bit) | req_rise) & ~imr_n);
    isr_n = (isr_q & ~isr_clr) | ack_bit;

    low_n = low_q;
    if (wr_evt && cmd.rot_top && isv_found) low_n = isv_lvl;
    if (wr_evt && cmd.set_low)              low_n = cmd.lvl;
    if (init_evt)                           low_n = LOW_DEF;

    smm_n    = smm_q;
    sel_n    = sel_isr_q;
    poll_n   = rd_evt ? 1'b0 : poll_q;
    second_n = second_q;
    if (wr_evt) begin
      second_n = cmd.init;
      if (cmd.smm_we)  smm_n  = cmd.smm_val;
      if (cmd.sel_we)  sel_n  = cmd.sel_val;
      if (cmd.mode_wr) poll_n = cmd.poll;
      if (cmd.init) begin
        smm_n  = 1'b0;
        sel_n  = 1'b0;
        poll_n = 1'b0;
      end
    end

    dout_n = dout;
    if (rd_evt) begin
      if (s_addr)       dout_n = DATA_W'(imr_q);
      else if (poll_q)  dout_n = grant ? {1'b1, {PAD_W{1'b0}}, req_lvl} : '0;
      else if (sel_isr_q) dout_n = DATA_W'(isr_q);
      else              dout_n = DATA_W'(irr_q);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_prev   <= 1'b1;
      rd_prev   <= 1'b1;
      req_prev  <= '0;
      irr_q     <= '0;
      isr_q     <= '0;
      imr_q     <= '0;
      low_q     <= LOW_DEF;
      smm_q     <= 1'b0;
      sel_isr_q <= 1'b0;
      poll_q    <= 1'b0;
      second_q  <= 1'b0;
      dout      <= '0;
      irq_out   <= 1'b0;
    end else begin
      wr_prev   <= s_wr_n;
      rd_prev   <= s_rd_n;
      req_prev  <= req_s;
      irr_q     <= irr_n;
      isr_q     <= isr_n;
      imr_q     <= imr_n;
      low_q     <= low_n;
      smm_q     <= smm_n;
      sel_isr_q <= sel_n;
      poll_q    <= poll_n;
      second_q  <= second_n;
      dout      <= dout_n;
      irq_out   <= grant;
    end
  end
endmodule

// File: rtl/pic_checker.sv
module pic_checker
  import pic_pkg::*;
(
  input logic               clk,
  input logic               rst,
  input logic [NUM_LVL-1:0] irr,
  input logic [NUM_LVL-1:0] isr,
  input logic [NUM_LVL-1:0] imr,
  input logic               poll,
  input logic               rd_evt,
  input logic               wr_evt,
  input logic               init_evt,
  input logic               irq_out,
  input logic [DATA_W-1:0]  dout
);
  AST_MASKED_REQ_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (irr & imr) == '0);                                              // R2
  AST_ACK_ONE_LEVEL: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> $countones(isr & ~$past(isr)) <= 1);                    // R4
  AST_POLL_ONE_SHOT: assert property (@(posedge clk) disable iff (rst)
    (poll && rd_evt && !wr_evt) |=> !poll);                          // R6
  AST_IRQ_HAS_SOURCE: assert property (@(posedge clk) disable iff (rst)
    irq_out |-> $past(irr != '0));                                   // R11
  AST_INIT_CLEARS_MASK: assert property (@(posedge clk) disable iff (rst)
    init_evt |=> (imr == '0 && irr == '0));                          // R12
  AST_DOUT_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !rd_evt |=> $stable(dout));                                      // R13
endmodule

bind poll_irq_ctrl pic_checker i_chk (
  .clk(clk), .rst(rst), .irr(irr_q), .isr(isr_q), .imr(imr_q),
  .poll(poll_q), .rd_evt(rd_evt), .wr_evt(wr_evt), .init_evt(init_evt),
  .irq_out(irq_out), .dout(dout)
);

// File: tb/test_poll_irq_ctrl.sv
`timescale 1ns/1ps
module test_poll_irq_ctrl;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cs_n = 1'b1, wr_n = 1'b1, rd_n = 1'b1, addr = 1'b0;
  logic [7:0] din = '0;
  logic [7:0] dout;
  logic [7:0] irq_req = '0;
  logic       irq_out;

  always #2 clk = ~clk;   // 250 MHz

  poll_irq_ctrl i_poll_irq_ctrl (
    .clk(clk), .rst(rst), .cs_n(cs_n), .wr_n(wr_n), .rd_n(rd_n), .addr(addr),
    .din(din), .dout(dout), .irq_req(irq_req), .irq_out(irq_out)
  );

  int tests = 0, fails = 0;
  int cyc = 0, last_stim = 0;
  bit done = 0;

  // ---------------- behavioural reference ----------------
  logic [7:0] m_irr = 0, m_isr = 0, m_imr = 0, m_line = 0;
  int m_low = 7;
  bit m_smm = 0, m_sel_isr = 0, m_poll = 0, m_second = 0;

  function automatic int m_rank(int l);
    return (l - m_low - 1 + 16) % 8;
  endfunction
  function automatic int m_top(logic [7:0] v);
    for (int r = 0; r < 8; r++) begin
      int l = (m_low + 1 + r) % 8;
      if (v[l]) return l;
    end
    return -1;
  endfunction
  function automatic int m_grant();
    int r, s;
    if (m_smm) return m_top(m_irr & ~m_isr);
    r = m_top(m_irr);
    s = m_top(m_isr);
    if (r < 0) return -1;
    if (s >= 0 && m_rank(r) >= m_rank(s)) return -1;
    return r;
  endfunction

  task automatic m_write(bit a, logic [7:0] d);
    int h;
    if (m_second) begin m_second = 0; return; end
    if (a) begin m_imr = d; m_irr &= ~d; return; end
    if (d[4]) begin
      m_imr = 0; m_irr = 0; m_smm = 0; m_sel_isr = 0; m_low = 7; m_poll = 0; m_second = 1;
    end else if (!d[3]) begin
      case (d[7:5])
        3'b001: begin h = m_top(m_isr); if (h >= 0) m_isr[h] = 0; end
        3'b101: begin h = m_top(m_isr); if (h >= 0) begin m_isr[h] = 0; m_low = h; end end
        3'b011: m_isr[d[2:0]] = 0;
        3'b110: m_low = d[2:0];
        3'b111: begin m_isr[d[2:0]] = 0; m_low = d[2:0]; end
        default: ;
      endcase
    end else begin
      if (d[6]) m_smm = d[5];
      if (d[1]) m_sel_isr = d[0];
      m_poll = d[2];
    end
  endtask

  task automatic m_read(bit a, output logic [7:0] v);
    int g;
    if (a) v = m_imr;
    else if (m_poll) begin
      g = m_grant();
      if (g >= 0) begin v = 8'h80 | 8'(g); m_isr[g] = 1; m_irr[g] = 0; end
      else v = 8'h00;
    end else v = m_sel_isr ? m_isr : m_irr;
    m_poll = 0;
  endtask

  // ---------------- checking ----------------
  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (!rst && !done && (cyc - last_stim) >= 6) begin
      tests++;
      if (irq_out !== (m_grant() >= 0)) begin   // R11 R1 R10 continuous
        fails++;
        $display("FAIL R11: irq_out actual %0b expected %0b at cycle %0d",
                 irq_out, m_grant() >= 0, cyc);
      end
    end
  end

  // ---------------- stimulus tasks ----------------
  task automatic bus_wr(bit a, logic [7:0] d, bit en = 1);
    @(negedge clk); addr = a; din = d; cs_n = ~en;
    repeat (2) @(negedge clk);
    wr_n = 0; last_stim = cyc;
    if (en) m_write(a, d);
    repeat (4) @(negedge clk);
    wr_n = 1; last_stim = cyc;
    repeat (2) @(negedge clk);
    cs_n = 1;
    repeat (6) @(negedge clk);
  endtask

  task automatic bus_rd(string tag, bit a, output logic [7:0] v, input int hold = 6);
    logic [7:0] e;
    @(negedge clk); addr = a; cs_n = 0;
    repeat (2) @(negedge clk);
    rd_n = 0; last_stim = cyc;
    m_read(a, e);
    repeat (hold) @(negedge clk);
    v = dout;
    check(tag, v, e);
    rd_n = 1; last_stim = cyc;
    repeat (2) @(negedge clk);
    cs_n = 1;
    repeat (6) @(negedge clk);
  endtask

  task automatic set_line(int k, bit v);
    @(negedge clk);
    if (v && !m_line[k] && !m_imr[k]) m_irr[k] = 1;
    m_line[k] = v;
    irq_req[k] = v;
    last_stim = cyc;
    repeat (8) @(negedge clk);
  endtask

  task automatic chk_irq(string tag, bit exp);
    tests++;
    if (irq_out !== exp) begin
      fails++;
      $display("FAIL %s: irq_out actual %0b expected %0b", tag, irq_out, exp);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1; tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    repeat (5) @(negedge clk);
    rst = 0; last_stim = cyc;
    check("R12 reset dout", dout, 8'h00);
    chk_irq("R12 reset irq", 0);

    // R1 edge capture
    set_line(3, 1);
    chk_irq("R1", 1);
    bus_rd("R1", 0, v); check("R1 irr", v, 8'h08);

    // R2 / R3 mask
    bus_wr(1, 8'h08);
    bus_rd("R3", 1, v); check("R3 mask read", v, 8'h08);
    bus_rd("R2", 0, v); check("R2 masked cleared", v, 8'h00);
    set_line(3, 0); set_line(3, 1);
    bus_wr(1, 8'h00);
    bus_rd("R2", 0, v); check("R2 lost edge", v, 8'h00);

    // R4 poll
    set_line(5, 1); set_line(2, 1);
    bus_wr(0, 8'h0C);
    bus_rd("R4", 0, v); check("R4 poll code", v, 8'h82);
    bus_rd("R6", 0, v); check("R6 one-shot poll", v, 8'h20);
    bus_wr(0, 8'h0B);
    bus_rd("R6", 0, v); check("R6 isr select", v, 8'h04);
    bus_rd("R6", 0, v); check("R6 select kept", v, 8'h04);

    // R11 nesting
    chk_irq("R11 lower held off", 0);
    set_line(1, 1);
    chk_irq("R11 higher passes", 1);
    bus_wr(0, 8'h0C);
    bus_rd("R4", 0, v); check("R4 nested poll", v, 8'h81);

    // R7 non-specific EOI
    bus_wr(0, 8'h20);
    bus_rd("R7", 0, v); check("R7 top cleared", v, 8'h04);

    // R10 special mask mode
    bus_wr(0, 8'h68);
    chk_irq("R10 smm on", 1);
    bus_wr(0, 8'h48);
    chk_irq("R10 smm off", 0);

    // R8 specific EOI
    bus_wr(0, 8'h62);
    bus_rd("R8", 0, v); check("R8 named cleared", v, 8'h00);

    // R6 poll overrides select in same word
    bus_wr(0, 8'h0E);
    bus_rd("R6", 0, v); check("R6 poll wins", v, 8'h85);
    bus_rd("R6", 0, v); check("R6 irr selected", v, 8'h00);

    // R5 empty poll
    bus_wr(0, 8'h0C);
    bus_rd("R5", 0, v); check("R5 empty poll", v, 8'h00);
    bus_wr(0, 8'h0B);
    bus_rd("R5", 0, v); check("R5 isr untouched", v, 8'h20);

    // R9 rotation
    set_line(1, 0); set_line(2, 0); set_line(3, 0); set_line(5, 0);
    bus_wr(0, 8'h65);
    bus_wr(0, 8'hC4);
    set_line(6, 1); set_line(0, 1);
    bus_wr(0, 8'h0C);
    bus_rd("R9", 0, v); check("R9 set lowest", v, 8'h86);
    bus_wr(0, 8'hA0);
    set_line(5, 1);
    bus_wr(0, 8'h0C);
    bus_rd("R9", 0, v); check("R9 rotate on eoi", v, 8'h80);
    bus_wr(0, 8'hE0);
    bus_wr(0, 8'h0B);
    bus_rd("R9", 0, v); check("R9 specific rotate", v, 8'h00);
    bus_wr(0, 8'h0C);
    bus_rd("R9", 0, v); check("R9 sole pending", v, 8'h85);

    // R12 initialisation
    bus_wr(0, 8'h6F);   // set smm so init must clear it
    bus_wr(0, 8'h13);
    bus_wr(1, 8'hFF);   // second word, discarded
    bus_rd("R12", 1, v); check("R12 mask clear", v, 8'h00);
    bus_rd("R12", 0, v); check("R12 irr clear, no re-edge", v, 8'h00);
    bus_wr(0, 8'h0B);
    bus_rd("R12", 0, v); check("R12 isr kept", v, 8'h20);
    bus_wr(0, 8'h20);
    set_line(0, 0); set_line(0, 1); set_line(7, 1);
    bus_wr(0, 8'h0C);
    bus_rd("R12", 0, v); check("R12 default priority", v, 8'h80);

    // R13 long strobe acts once, chip select gating
    bus_wr(0, 8'h20);
    set_line(3, 1);
    bus_wr(0, 8'h0C);
    bus_rd("R13", 0, v, 30); check("R13 long poll", v, 8'h83);
    bus_wr(0, 8'h0A);
    bus_rd("R13", 0, v); check("R13 one ack only", v, 8'h80);
    bus_wr(1, 8'hFF, 0);
    bus_rd("R13", 1, v); check("R13 cs gating", v, 8'h00);

    repeat (10) @(negedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule